// File: doc/BRIEF.md
# Descriptor Ring Copy Queue Controller

This block is the hardware side of a single memory-to-memory copy queue. Software builds 32-byte command descriptors in a ring in memory, programs the ring location and size, sets the run bit and then moves a tail pointer forward. Whenever the queue is running and its head pointer differs from its tail, the controller reads the descriptor at the head, one 32-bit word per cycle. It then hands a single copy request to an external data mover and waits for the response.

A good response moves the head one descriptor forward, wrapping at the end of the ring, and updates the interrupt status. An error response freezes the queue on the failing descriptor and records the error code. Software recovers by writing the head equal to the tail, which drops the remaining descriptors. Status bits are cleared by writing ones, and one interrupt line reports every status bit whose enable is set.

Top module: `ringCopyQueue`

## Requirements
- R1: After reset the control, tail, head, interrupt enable, interrupt status and queue status registers read zero, and irqOut is low.
- R2: While run (control bit 0) is set and head differs from tail, the controller reads the six descriptor words at byte address {control[31:16], head} + 4*k and issues one copy request. The request carries length = word 1, source = {word 3[15:0], word 2}, source type = word 3[17:16], destination = {word 5[15:0], word 4] and destination type = word 5[17:16]. The request holds steady until it is accepted.
- R3: After a good copy response the head advances by 32 bytes and wraps inside a ring of 2^(code+1) entries, where code = control[7:3]. Head/tail comparison uses only the ring-index bits.
- R4: Several descriptors released by a single tail write are issued one at a time, in ring order, until head equals tail. Then the empty status bit (bit 3) is set.
- R5: The completion status bit (bit 0) is set after a good response exactly when descriptor word 0 bit 1 is set.
- R6: When a command finishes with descriptor word 0 bit 0 set, or with run cleared by software while it was in flight, run ends at 0 and the stopped bit (bit 2) is set. No further descriptor is fetched.
- R7: An error response puts its 6-bit code in queue status (offset 0x100) bits 5:0, sets the error bit (bit 1) and clears run, and the head is not advanced. Writing the head (offset 0x008) equal to the tail while idle discards the pending descriptors.
- R8: Writing the interrupt status register (offset 0x010) clears exactly the bits written as 1.
- R9: irqOut is high exactly when some status bit has its matching bit in the interrupt enable register (offset 0x00C) set. Offset 0x104 reads status AND enable.
- R10: While the halt bit (control bit 1) is set, no new descriptor is started, and run keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| descRdEn | output | 1 | Descriptor word read request |
| descRdAddr | output | 48 | Byte address of the descriptor word |
| descRdData | input | 32 | Descriptor word, valid the cycle after descRdEn |
| copyReqValid | output | 1 | Copy request valid |
| copyReqReady | input | 1 | Copy request accepted |
| copySrc | output | 48 | Source byte address |
| copySrcType | output | 2 | Source memory type |
| copyDst | output | 48 | Destination byte address |
| copyDstType | output | 2 | Destination memory type |
| copyLen | output | 32 | Byte count |
| copyRspValid | input | 1 | Copy response strobe |
| copyRspErr | input | 1 | Copy failed |
| copyRspCode | input | 6 | Failure code |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 16 upper address bits, rings of up to 32 entries and 6-bit error codes. It programs size code 1, so the ring has four entries and the wrap of the head is reached after four descriptors. With a nonzero upper address field, the bench can check that the field reaches the descriptor reads. Because the response delay is programmable, software can clear run while a command is still in flight.

// File: rtl/rcqPkg.sv
package rcqPkg;
  // register offsets (byte address within the queue window)
  localparam logic [11:0] OFF_CTRL = 12'h000;
  localparam logic [11:0] OFF_TAIL = 12'h004;
  localparam logic [11:0] OFF_HEAD = 12'h008;
  localparam logic [11:0] OFF_IEN  = 12'h00C;
  localparam logic [11:0] OFF_ISTS = 12'h010;
  localparam logic [11:0] OFF_QSTS = 12'h100;
  localparam logic [11:0] OFF_QINT = 12'h104;

  // descriptor geometry: six meaningful words inside a 32-byte slot
  localparam int DESC_WORDS = 6;
  localparam int DESC_SHIFT = 5;
  localparam int IDX_W      = DESC_SHIFT - 2;

  localparam logic [IDX_W-1:0] W_CTL   = 3'd0;
  localparam logic [IDX_W-1:0] W_LEN   = 3'd1;
  localparam logic [IDX_W-1:0] W_SRCLO = 3'd2;
  localparam logic [IDX_W-1:0] W_SRCHI = 3'd3;
  localparam logic [IDX_W-1:0] W_DSTLO = 3'd4;
  localparam logic [IDX_W-1:0] W_DSTHI = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DRAIN,
    ST_ISSUE,
    ST_WAIT
  } rcqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             busy;
    logic             fetchEn;
    logic [IDX_W-1:0] wordIdx;
    logic             advanceHead;
    logic             setComp;
    logic             setErr;
    logic             setStop;
    logic             setEmpty;
    logic             clearRun;
  } rcqStrobe_t;
endpackage

// File: rtl/rcqCtrl.sv
module rcqCtrl
  import rcqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       halt,
  input  logic       ringEmpty,
  input  logic       nextHitsTail,
  input  logic       descStop,
  input  logic       descIoc,
  input  logic       copyReqReady,
  input  logic       copyRspValid,
  input  logic       copyRspErr,
  output rcqStrobe_t stb,
  output logic       copyReqValid
);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(DESC_WORDS - 1);

  rcqState_e        state, stateNx;
  logic [IDX_W-1:0] idx, idxNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= stateNx;
      idx   <= idxNx;
    end
  end

  always_comb begin
    stb          = '0;
    stateNx      = state;
    idxNx        = idx;
    copyReqValid = 1'b0;
    stb.busy     = (state != ST_IDLE);
    stb.wordIdx  = idx;
    case (state)
      ST_IDLE: begin
        if (run && !halt && !ringEmpty) begin
          stateNx = ST_FETCH;
          idxNx   = '0;
        end
      end
      ST_FETCH: begin
        stb.fetchEn = 1'b1;
        if (idx == LAST_WORD) stateNx = ST_DRAIN;
        else                  idxNx   = idx + 1'b1;
      end
      ST_DRAIN: stateNx = ST_ISSUE;
      ST_ISSUE: begin
        copyReqValid = 1'b1;
        if (copyReqReady) stateNx = ST_WAIT;
      end
      ST_WAIT: begin
        if (copyRspValid) begin
          stateNx = ST_IDLE;
          if (copyRspErr) begin
            stb.setErr   = 1'b1;
            stb.clearRun = 1'b1;
          end else begin
            stb.advanceHead = 1'b1;
            stb.setComp     = descIoc;
            stb.setEmpty    = nextHitsTail;
            stb.setStop     = descStop || !run;
            stb.clearRun    = descStop;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/rcqData.sv
module rcqData
  import rcqPkg::*;
#(
  parameter  int ADDR_HI_W     = 16,
  parameter  int MAX_RING_LOG2 = 5,
  parameter  int ERR_W         = 6,
  localparam int PHYS_AW       = 32 + ADDR_HI_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [11:0]        regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  rcqStrobe_t         stb,
  output logic [PHYS_AW-1:0] descRdAddr,
  input  logic [31:0]        descRdData,
  input  logic [ERR_W-1:0]   copyRspCode,
  output logic [PHYS_AW-1:0] copySrc,
  output logic [1:0]         copySrcType,
  output logic [PHYS_AW-1:0] copyDst,
  output logic [1:0]         copyDstType,
  output logic [31:0]        copyLen,
  output logic               run,
  output logic               halt,
  output logic               ringEmpty,
  output logic               nextHitsTail,
  output logic               descStop,
  output logic               descIoc,
  output logic [31:0]        headPtr,
  output logic [3:0]         intEnable,
  output logic               irqOut
);
  localparam int          STEP_BYTES = 1 << DESC_SHIFT;
  localparam logic [31:0] STEP       = 32'(STEP_BYTES);

  logic [31:0]      ctrlReg, tailPtr;
  logic [3:0]       intSts;
  logic [ERR_W-1:0] errCode;

  // ring geometry
  logic [5:0]  sizeCode, ringLog2;
  logic [31:0] ringMask, headNext;

  assign sizeCode = {1'b0, ctrlReg[7:3]} + 6'd1;
  assign ringLog2 = (sizeCode > 6'(MAX_RING_LOG2)) ? 6'(MAX_RING_LOG2) : sizeCode;

  always_comb begin
    for (int i = 0; i < 32; i++) begin
      ringMask[i] = (i >= DESC_SHIFT) && (i < DESC_SHIFT + int'(ringLog2));
    end
  end

  assign headNext     = (headPtr & ~ringMask) | ((headPtr + STEP) & ringMask);
  assign ringEmpty    = ((headPtr ^ tailPtr) & ringMask) == 32'd0;
  assign nextHitsTail = ((headNext ^ tailPtr) & ringMask) == 32'd0;
  assign run          = ctrlReg[0];
  assign halt         = ctrlReg[1];

  // register writes
  logic wrCtrl, wrTail, wrHead, wrIen, wrIsts;
  assign wrCtrl = regWrEn && (regAddr == OFF_CTRL);
  assign wrTail = regWrEn && (regAddr == OFF_TAIL);
  assign wrHead = regWrEn && (regAddr == OFF_HEAD);
  assign wrIen  = regWrEn && (regAddr == OFF_IEN);
  assign wrIsts = regWrEn && (regAddr == OFF_ISTS);

  logic [3:0] setMask, clrMask;
  assign setMask = {stb.setEmpty, stb.setStop, stb.setErr, stb.setComp};
  assign clrMask = wrIsts ? regWrData[3:0] : 4'd0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      tailPtr   <= '0;
      headPtr   <= '0;
      intEnable <= '0;
      intSts    <= '0;
      errCode   <= '0;
    end else begin
      if (wrCtrl)       ctrlReg    <= regWrData;
      if (stb.clearRun) ctrlReg[0] <= 1'b0;
      if (wrTail)       tailPtr    <= regWrData;
      if (stb.advanceHead)           headPtr <= headNext;
      else if (wrHead && !stb.busy)  headPtr <= regWrData;
      if (wrIen)        intEnable  <= regWrData[3:0];
      intSts <= (intSts & ~clrMask) | setMask;
      if (stb.setErr)   errCode    <= copyRspCode;
    end
  end

  always_comb begin
    case (regAddr)
      OFF_CTRL: regRdData = ctrlReg;
      OFF_TAIL: regRdData = tailPtr;
      OFF_HEAD: regRdData = headPtr;
      OFF_IEN:  regRdData = {28'd0, intEnable};
      OFF_ISTS: regRdData = {28'd0, intSts};
      OFF_QSTS: regRdData = 32'(errCode);
      OFF_QINT: regRdData = {28'd0, intSts & intEnable};
      default:  regRdData = 32'd0;
    endcase
  end

  assign irqOut = |(intSts & intEnable);

  // descriptor fetch and capture
  assign descRdAddr = {ctrlReg[16 +: ADDR_HI_W], headPtr[31:DESC_SHIFT], stb.wordIdx, 2'b00};

  logic             capValid;
  logic [IDX_W-1:0] capIdx;
  logic [1:0]       dCtl;
  logic [31:0]      dLen, dSrcLo, dDstLo;
  logic [ADDR_HI_W-1:0] dSrcHi, dDstHi;
  logic [1:0]       dSrcType, dDstType;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capIdx   <= '0;
    end else begin
      capValid <= stb.fetchEn;
      capIdx   <= stb.wordIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dCtl     <= '0;
      dLen     <= '0;
      dSrcLo   <= '0;
      dSrcHi   <= '0;
      dSrcType <= '0;
      dDstLo   <= '0;
      dDstHi   <= '0;
      dDstType <= '0;
    end else if (capValid) begin
      case (capIdx)
        W_CTL:   dCtl   <= descRdData[1:0];
        W_LEN:   dLen   <= descRdData;
        W_SRCLO: dSrcLo <= descRdData;
        W_SRCHI: begin
          dSrcHi   <= descRdData[ADDR_HI_W-1:0];
          dSrcType <= descRdData[17:16];
        end
        W_DSTLO: dDstLo <= descRdData;
        W_DSTHI: begin
          dDstHi   <= descRdData[ADDR_HI_W-1:0];
          dDstType <= descRdData[17:16];
        end
        default: ;
      endcase
    end
  end

  assign descStop    = dCtl[0];
  assign descIoc     = dCtl[1];
  assign copyLen     = dLen;
  assign copySrc     = {dSrcHi, dSrcLo};
  assign copySrcType = dSrcType;
  assign copyDst     = {dDstHi, dDstLo};
  assign copyDstType = dDstType;
endmodule

// File: rtl/ringCopyQueue.sv
module ringCopyQueue
  import rcqPkg::*;
#(
  parameter  int ADDR_HI_W     = 16,
  parameter  int MAX_RING_LOG2 = 5,
  parameter  int ERR_W         = 6,
  localparam int PHYS_AW       = 32 + ADDR_HI_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [11:0]        regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               descRdEn,
  output logic [PHYS_AW-1:0] descRdAddr,
  input  logic [31:0]        descRdData,
  output logic               copyReqValid,
  input  logic               copyReqReady,
  output logic [PHYS_AW-1:0] copySrc,
  output logic [1:0]         copySrcType,
  output logic [PHYS_AW-1:0] copyDst,
  output logic [1:0]         copyDstType,
  output logic [31:0]        copyLen,
  input  logic               copyRspValid,
  input  logic               copyRspErr,
  input  logic [ERR_W-1:0]   copyRspCode,
  output logic               irqOut
);
  rcqStrobe_t  stb;
  logic        ctrlRun, ctrlHalt, ringEmpty, nextHitsTail, descStop, descIoc;
  logic [31:0] headPtr;
  logic [3:0]  intEnable;
  logic        busy;

  assign descRdEn = stb.fetchEn;
  assign busy     = stb.busy;

  rcqCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .run          (ctrlRun),
    .halt         (ctrlHalt),
    .ringEmpty    (ringEmpty),
    .nextHitsTail (nextHitsTail),
    .descStop     (descStop),
    .descIoc      (descIoc),
    .copyReqReady (copyReqReady),
    .copyRspValid (copyRspValid),
    .copyRspErr   (copyRspErr),
    .stb          (stb),
    .copyReqValid (copyReqValid)
  );

  rcqData #(
    .ADDR_HI_W     (ADDR_HI_W),
    .MAX_RING_LOG2 (MAX_RING_LOG2),
    .ERR_W         (ERR_W)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .stb          (stb),
    .descRdAddr   (descRdAddr),
    .descRdData   (descRdData),
    .copyRspCode  (copyRspCode),
    .copySrc      (copySrc),
    .copySrcType  (copySrcType),
    .copyDst      (copyDst),
    .copyDstType  (copyDstType),
    .copyLen      (copyLen),
    .run          (ctrlRun),
    .halt         (ctrlHalt),
    .ringEmpty    (ringEmpty),
    .nextHitsTail (nextHitsTail),
    .descStop     (descStop),
    .descIoc      (descIoc),
    .headPtr      (headPtr),
    .intEnable    (intEnable),
    .irqOut       (irqOut)
  );
endmodule

// File: rtl/rcqChk.sv
module rcqChk
  import rcqPkg::*;
#(
  parameter int PHYS_AW = 48
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [11:0]        regAddr,
  input logic               copyReqValid,
  input logic               copyReqReady,
  input logic [PHYS_AW-1:0] copySrc,
  input logic [PHYS_AW-1:0] copyDst,
  input logic [31:0]        copyLen,
  input logic               copyRspValid,
  input logic               copyRspErr,
  input logic               descRdEn,
  input logic               irqOut,
  input logic               ctrlRun,
  input logic               ctrlHalt,
  input logic [31:0]        headPtr,
  input logic [3:0]         intEnable,
  input logic               busy
);
  // R2: a pending copy request keeps its fields until accepted
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (copyReqValid && !copyReqReady) |=>
      (copyReqValid && $stable(copySrc) && $stable(copyDst) && $stable(copyLen)));

  // R3: head moves only after a copy response or a software head write
  a_r3_head_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(headPtr) |-> ($past(copyRspValid) || $past(regWrEn && (regAddr == OFF_HEAD))));

  // R7: an error response leaves the queue with run cleared
  a_r7_err_clears_run: assert property (@(posedge clk) disable iff (!rstN)
    (busy && copyRspValid && copyRspErr) |=> !ctrlRun);

  // R10 and R6: an idle queue that is halted or not running starts no fetch
  a_r10_no_fetch_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (ctrlHalt || !ctrlRun)) |=> !descRdEn);

  // R9: with every enable off the interrupt line stays low
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable == 4'd0) |-> !irqOut);
endmodule

bind ringCopyQueue rcqChk #(.PHYS_AW(PHYS_AW)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regAddr      (regAddr),
  .copyReqValid (copyReqValid),
  .copyReqReady (copyReqReady),
  .copySrc      (copySrc),
  .copyDst      (copyDst),
  .copyLen      (copyLen),
  .copyRspValid (copyRspValid),
  .copyRspErr   (copyRspErr),
  .descRdEn     (descRdEn),
  .irqOut       (irqOut),
  .ctrlRun      (ctrlRun),
  .ctrlHalt     (ctrlHalt),
  .headPtr      (headPtr),
  .intEnable    (intEnable),
  .busy         (busy)
);

// File: tb/ringCopyQueue_tb.sv
`timescale 1ns/1ps
module ringCopyQueue_tb;
  localparam logic [31:0] RING_BASE = 32'h0000_0200;
  localparam logic [31:0] CTRL_IDLE = 32'h0012_0008; // hi addr 0x12, size code 1 (4 entries)
  localparam logic [31:0] CTRL_RUN  = 32'h0012_0009;
  localparam logic [31:0] CTRL_HALT = 32'h0012_000B;

  typedef struct packed {
    logic [1:0]  ctl;
    logic [31:0] len;
    logic [31:0] srcLo;
    logic [15:0] srcHi;
    logic [1:0]  srcTy;
    logic [31:0] dstLo;
    logic [15:0] dstHi;
    logic [1:0]  dstTy;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'b10, 32'h0000_0040, 32'h0000_1000, 16'h0001, 2'd1, 32'h0000_2000, 16'h0002, 2'd2},
    '{2'b00, 32'h0000_0001, 32'hFFFF_FFFC, 16'hFFFF, 2'd3, 32'h8000_0000, 16'h0000, 2'd0},
    '{2'b10, 32'h7FFF_FFFF, 32'h1234_5678, 16'hABCD, 2'd0, 32'h9ABC_DEF0, 16'h1357, 2'd3},
    '{2'b11, 32'h0000_0200, 32'h0BAD_F00D, 16'h0042, 2'd2, 32'h0000_0000, 16'h7FFF, 2'd1},
    '{2'b10, 32'h0000_1234, 32'h5555_AAAA, 16'h00FF, 2'd1, 32'hAAAA_5555, 16'hFF00, 2'd2},
    '{2'b00, 32'h0000_0F00, 32'h0000_0004, 16'h0000, 2'd0, 32'hFFFF_FFF0, 16'hFFFF, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        descRdEn;
  logic [47:0] descRdAddr;
  logic [31:0] descRdData = '0;
  logic        copyReqValid;
  logic        copyReqReady = 1'b1;
  logic [47:0] copySrc, copyDst;
  logic [1:0]  copySrcType, copyDstType;
  logic [31:0] copyLen;
  logic        copyRspValid = 1'b0;
  logic        copyRspErr = 1'b0;
  logic [5:0]  copyRspCode = '0;
  logic        irqOut;

  ringCopyQueue u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .descRdEn(descRdEn), .descRdAddr(descRdAddr), .descRdData(descRdData),
    .copyReqValid(copyReqValid), .copyReqReady(copyReqReady), .copySrc(copySrc),
    .copySrcType(copySrcType), .copyDst(copyDst), .copyDstType(copyDstType), .copyLen(copyLen),
    .copyRspValid(copyRspValid), .copyRspErr(copyRspErr), .copyRspCode(copyRspCode), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // memory and mover models
  logic [31:0] mem [256];
  logic [15:0] lastHi = '0;
  int          copyCount = 0;
  int          rspLatency = 2;
  logic [31:0] logLen [64];
  logic [47:0] logSrc [64];
  logic [47:0] logDst [64];
  logic [1:0]  logSrcTy [64];
  logic [1:0]  logDstTy [64];

  initial begin
    logic       pendValid;
    logic [7:0] pendIdx;
    pendValid = 1'b0;
    pendIdx   = '0;
    forever begin
      @(negedge clk);
      descRdData = pendValid ? mem[pendIdx] : 32'd0;
      pendValid  = descRdEn;
      pendIdx    = descRdAddr[9:2];
      if (descRdEn) lastHi = descRdAddr[47:32];
    end
  end

  initial begin
    logic       busyRsp;
    int         cnt;
    logic       pErr;
    logic [5:0] pCode;
    busyRsp = 1'b0;
    cnt = 0;
    pErr = 1'b0;
    pCode = '0;
    forever begin
      @(negedge clk);
      copyRspValid = 1'b0;
      if (busyRsp) begin
        if (cnt == 0) begin
          copyRspValid = 1'b1;
          copyRspErr   = pErr;
          copyRspCode  = pCode;
          busyRsp      = 1'b0;
        end else cnt--;
      end
      if (copyReqValid && copyReqReady) begin
        logLen[copyCount % 64]   = copyLen;
        logSrc[copyCount % 64]   = copySrc;
        logDst[copyCount % 64]   = copyDst;
        logSrcTy[copyCount % 64] = copySrcType;
        logDstTy[copyCount % 64] = copyDstType;
        copyCount++;
        busyRsp = 1'b1;
        cnt     = rspLatency;
        pErr    = copyLen[31];
        pCode   = copyLen[5:0];
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic putDesc(input int slot, input vec_t v);
    int b;
    b = int'(RING_BASE >> 2) + slot * 8;
    mem[b + 0] = {30'd0, v.ctl};
    mem[b + 1] = v.len;
    mem[b + 2] = v.srcLo;
    mem[b + 3] = {14'd0, v.srcTy, v.srcHi};
    mem[b + 4] = v.dstLo;
    mem[b + 5] = {14'd0, v.dstTy, v.dstHi};
  endtask

  function automatic logic [31:0] slotAddr(input int slot);
    return RING_BASE + 32'((slot % 4) * 32);
  endfunction

  function automatic vec_t mkDesc(input logic [1:0] ctl, input logic [31:0] len);
    vec_t v;
    v = '{ctl, len, 32'h0000_3000, 16'h0003, 2'd0, 32'h0000_4000, 16'h0004, 2'd1};
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          c0;
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(12'h000, rd); chk("R1 ctrl", 64'(rd), 64'd0);
    regRead(12'h004, rd); chk("R1 tail", 64'(rd), 64'd0);
    regRead(12'h008, rd); chk("R1 head", 64'(rd), 64'd0);
    regRead(12'h00C, rd); chk("R1 ien", 64'(rd), 64'd0);
    regRead(12'h010, rd); chk("R1 ists", 64'(rd), 64'd0);
    regRead(12'h100, rd); chk("R1 qsts", 64'(rd), 64'd0);
    chk("R1 irq", 64'(irqOut), 64'd0);

    regWrite(12'h008, RING_BASE);
    regWrite(12'h004, RING_BASE);
    regWrite(12'h00C, 32'hF);
    regWrite(12'h000, CTRL_RUN);

    // table-driven single descriptors (R2 R3 R5 R6 R4)
    for (int v = 0; v < 6; v++) begin
      c0 = copyCount;
      putDesc(v % 4, VECS[v]);
      regWrite(12'h004, slotAddr(v + 1));
      waitCycles(40);
      chk("R2 issued", 64'(copyCount), 64'(c0 + 1));
      chk("R2 len", 64'(logLen[c0 % 64]), 64'(VECS[v].len));
      chk("R2 src", 64'(logSrc[c0 % 64]), 64'({VECS[v].srcHi, VECS[v].srcLo}));
      chk("R2 srcType", 64'(logSrcTy[c0 % 64]), 64'(VECS[v].srcTy));
      chk("R2 dst", 64'(logDst[c0 % 64]), 64'({VECS[v].dstHi, VECS[v].dstLo}));
      chk("R2 dstType", 64'(logDstTy[c0 % 64]), 64'(VECS[v].dstTy));
      regRead(12'h008, rd); chk("R3 head wrap", 64'(rd), 64'(slotAddr(v + 1)));
      regRead(12'h010, rd);
      chk("R5 R6 status", 64'(rd), 64'({1'b1, VECS[v].ctl[0], 1'b0, VECS[v].ctl[1]}));
      regRead(12'h000, rd); chk("R6 run after stop bit", 64'(rd[0]), 64'(!VECS[v].ctl[0]));
      regWrite(12'h010, 32'hF);
      if (VECS[v].ctl[0]) regWrite(12'h000, CTRL_RUN);
    end

    // R4 batch of three from one tail write, wrapping the ring
    c0 = copyCount;
    putDesc(2, mkDesc(2'b00, 32'h11));
    putDesc(3, mkDesc(2'b00, 32'h22));
    putDesc(0, mkDesc(2'b00, 32'h33));
    regWrite(12'h004, slotAddr(1));
    waitCycles(90);
    chk("R4 count", 64'(copyCount), 64'(c0 + 3));
    chk("R4 order0", 64'(logLen[c0 % 64]), 64'h11);
    chk("R4 order1", 64'(logLen[(c0 + 1) % 64]), 64'h22);
    chk("R4 order2", 64'(logLen[(c0 + 2) % 64]), 64'h33);
    regRead(12'h008, rd); chk("R3 head after batch", 64'(rd), 64'(slotAddr(1)));
    regRead(12'h010, rd); chk("R4 R5 empty only", 64'(rd), 64'h8);
    chk("R2 upper address", 64'(lastHi), 64'h0012);
    regWrite(12'h010, 32'hF);

    // R7 error and flush
    c0 = copyCount;
    putDesc(1, mkDesc(2'b10, 32'h8000_002A));
    putDesc(2, mkDesc(2'b10, 32'h55));
    regWrite(12'h004, slotAddr(3));
    waitCycles(60);
    chk("R7 one issued", 64'(copyCount), 64'(c0 + 1));
    regRead(12'h100, rd); chk("R7 code", 64'(rd), 64'h2A);
    regRead(12'h010, rd); chk("R7 err bit", 64'(rd), 64'h2);
    regRead(12'h000, rd); chk("R7 run cleared", 64'(rd), 64'(CTRL_IDLE));
    regRead(12'h008, rd); chk("R7 head held", 64'(rd), 64'(slotAddr(1)));
    chk("R9 irq on error", 64'(irqOut), 64'd1);
    regWrite(12'h008, slotAddr(3));
    regWrite(12'h000, CTRL_RUN);
    waitCycles(40);
    chk("R7 flushed none issued", 64'(copyCount), 64'(c0 + 1));
    regRead(12'h008, rd); chk("R7 head flushed", 64'(rd), 64'(slotAddr(3)));

    // R8 write one to clear
    regWrite(12'h010, 32'h1);
    regRead(12'h010, rd); chk("R8 other bits kept", 64'(rd), 64'h2);
    regWrite(12'h010, 32'h2);
    regRead(12'h010, rd); chk("R8 bit cleared", 64'(rd), 64'h0);

    // R9 masking
    regWrite(12'h00C, 32'h0);
    putDesc(3, mkDesc(2'b10, 32'h66));
    regWrite(12'h004, slotAddr(0));
    waitCycles(40);
    regRead(12'h010, rd); chk("R9 status set", 64'(rd), 64'h9);
    chk("R9 irq masked", 64'(irqOut), 64'd0);
    regRead(12'h104, rd); chk("R9 masked view", 64'(rd), 64'h0);
    regWrite(12'h00C, 32'h1);
    #1 chk("R9 irq enabled", 64'(irqOut), 64'd1);
    regRead(12'h104, rd); chk("R9 masked view on", 64'(rd), 64'h1);
    regWrite(12'h010, 32'hF);
    regWrite(12'h00C, 32'hF);
    #1 chk("R9 irq after clear", 64'(irqOut), 64'd0);

    // R6 software clears run mid-flight
    rspLatency = 20;
    c0 = copyCount;
    putDesc(0, mkDesc(2'b00, 32'h77));
    regWrite(12'h004, slotAddr(1));
    waitCycles(12);
    regWrite(12'h000, CTRL_IDLE);
    waitCycles(50);
    chk("R6 in-flight completed", 64'(copyCount), 64'(c0 + 1));
    regRead(12'h008, rd); chk("R6 head advanced", 64'(rd), 64'(slotAddr(1)));
    regRead(12'h010, rd); chk("R6 stopped and empty", 64'(rd), 64'hC);
    rspLatency = 2;
    regWrite(12'h010, 32'hF);
    putDesc(1, mkDesc(2'b00, 32'h88));
    regWrite(12'h004, slotAddr(2));
    waitCycles(40);
    chk("R6 no fetch when stopped", 64'(copyCount), 64'(c0 + 1));

    // R10 halt
    regWrite(12'h000, CTRL_HALT);
    waitCycles(40);
    chk("R10 halted none issued", 64'(copyCount), 64'(c0 + 1));
    regRead(12'h000, rd); chk("R10 run kept", 64'(rd), 64'(CTRL_HALT));
    regRead(12'h008, rd); chk("R10 head held", 64'(rd), 64'(slotAddr(1)));
    regWrite(12'h000, CTRL_RUN);
    waitCycles(40);
    chk("R10 resumes", 64'(copyCount), 64'(c0 + 2));
    chk("R10 resumed len", 64'(logLen[(c0 + 1) % 64]), 64'h88);
    regRead(12'h008, rd); chk("R10 head after resume", 64'(rd), 64'(slotAddr(2)));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule